// File: doc/BRIEF.md
# ATA PIO Strobe Timing Generator

This block produces the read and write strobes for parallel ATA register and PIO data cycles. Each cycle has three phases: an address-setup phase with both strobes deasserted, an active phase with the selected strobe asserted, and a recovery phase with the strobe deasserted again. Each phase lasts a whole number of bus clocks. The phase lengths come from timing bytes that are held per drive and written through a small synchronous register port. Four drives are served over two channels. Drives 0 and 1 form the primary channel, and drives 2 and 3 form the secondary channel.

The count fields are packed tightly. A zero nibble stands for the longest count. Recovery is stored as the count minus one. Setup uses a 2-bit code that does not rise monotonically with the clock count. On the primary channel each drive has its own setup byte, and the hardware always applies the slower of the two. The secondary channel has a single setup byte shared by both of its drives.

A request is taken only while the block is idle. All counts are captured when the request is accepted, so register writes made during a running cycle apply only to later cycles. Busy covers the whole cycle, and a one-clock done pulse marks its final clock.

Top module: `pio_strobe_gen`

## Requirements
- R1: After reset, busy, done and both strobes are low. Every drive times at 5 setup, 16 active and 16 recovery clocks until its registers are written.
- R2: An accepted cycle runs as follows. The setup clocks come first with both strobes low. The strobe is then high for the active count and low again for the recovery count. Only rd_stb is used for a read and only wr_stb for a write. Busy stays high for the whole cycle. Done is high only on the last recovery clock, and busy is low on the following clock.
- R3: The active count is bits 7:4 of the data timing byte at register address equal to the drive number (0 to 3). A value of 0 gives 16 clocks, and 1 to 15 give that many clocks.
- R4: The recovery count is taken from bits 3:0 of the same byte. A value of 0 gives 16 clocks, and a value v from 1 to 15 gives v+1 clocks, so 15 also gives 16.
- R5: A setup code sits in bits 7:6 of a setup byte. Code 01 gives 2 clocks, 10 gives 3, 00 gives 4 and 11 gives 5. Bits 5:0 have no effect on timing.
- R6: Drives 0 and 1 use setup bytes at addresses 4 and 5. Both drives always get the longer of the two setup counts.
- R7: Drives 2 and 3 both use the single setup byte at address 6. Addresses 4 and 5 do not affect them.
- R8: A request made while busy is dropped. The running cycle keeps its timing, and no further cycle starts afterwards.
- R9: A timing register write made during a running cycle does not change that cycle. It applies from the next accepted cycle onward.
- R10: A write to register address 7 changes no timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 3 | Register address: 0 to 3 data timing, 4 and 5 primary setup, 6 secondary setup |
| reg_wdata | input | 8 | Register write data |
| req_valid | input | 1 | Cycle request, taken when idle |
| req_write | input | 1 | 1 for a write cycle, 0 for a read cycle |
| req_drive | input | 2 | Drive number; bit 1 selects the channel |
| rd_stb | output | 1 | Read strobe, active high |
| wr_stb | output | 1 | Write strobe, active high |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-clock pulse on the final clock of a cycle |

## Verification
If a phase counter or a captured count is corrupted, the cycle length changes, and the bench sees this during the same cycle. It measures setup, active and recovery lengths on the strobes and on busy, and compares each one with a value decoded from its own copy of the written bytes. A wrong state in the phase machine shows up within one clock. The symptoms are the wrong strobe, an early or repeated done, or busy dropping without done. The captured-timing property is probed by writing registers and raising requests in the middle of a cycle, and then checking both the running cycle and the one after it.

// File: rtl/pio_timing_pkg.sv
package pio_timing_pkg;
  parameter int NIB_W    = 4;
  parameter int NUM_DRV  = 4;
  parameter int SCODE_W  = 2;
  localparam int CNT_W   = NIB_W + 1;
  localparam int DRV_W   = $clog2(NUM_DRV);
  localparam int BYTE_W  = 2 * NIB_W;
  localparam int NUM_SET = 3;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_ACT   = 2'd2,
    PH_REC   = 2'd3
  } phase_e;

  // zero nibble stands for the full range
  function automatic logic [CNT_W-1:0] dec_active(input logic [NIB_W-1:0] v);
    return (v == '0) ? CNT_W'(1 << NIB_W) : CNT_W'(v);
  endfunction

  // stored as count-1, with zero meaning the full range
  function automatic logic [CNT_W-1:0] dec_recov(input logic [NIB_W-1:0] v);
    return (v == '0) ? CNT_W'(1 << NIB_W) : CNT_W'(v) + CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] dec_setup(input logic [SCODE_W-1:0] c);
    logic [CNT_W-1:0] r;
    case (c)
      2'b01:   r = CNT_W'(2);
      2'b10:   r = CNT_W'(3);
      2'b00:   r = CNT_W'(4);
      default: r = CNT_W'(5);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pio_timing_regs.sv
module pio_timing_regs
  import pio_timing_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [2:0]        addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [DRV_W-1:0]  drive,
  output logic [CNT_W-1:0]  setup_clks,
  output logic [CNT_W-1:0]  active_clks,
  output logic [CNT_W-1:0]  recov_clks
);
  logic [BYTE_W-1:0]  data_q [NUM_DRV];
  logic [SCODE_W-1:0] scode_q [NUM_SET];

  genvar g;
  generate
    for (g = 0; g < NUM_DRV; g++) begin : g_data
      logic en;
      assign en = we && (addr == 3'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  data_q[g] <= '0;
        else if (en) data_q[g] <= wdata;
      end
    end
    for (g = 0; g < NUM_SET; g++) begin : g_setup
      logic en;
      assign en = we && (addr == 3'(NUM_DRV + g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  scode_q[g] <= '1;
        else if (en) scode_q[g] <= wdata[BYTE_W-1 -: SCODE_W];
      end
    end
  endgenerate

  logic [BYTE_W-1:0] sel_byte;
  logic [CNT_W-1:0]  s_pri0, s_pri1, s_sec;

  always_comb begin
    sel_byte    = data_q[drive];
    active_clks = dec_active(sel_byte[BYTE_W-1 -: NIB_W]);
    recov_clks  = dec_recov(sel_byte[NIB_W-1:0]);
    s_pri0      = dec_setup(scode_q[0]);
    s_pri1      = dec_setup(scode_q[1]);
    s_sec       = dec_setup(scode_q[2]);
    if (drive[DRV_W-1]) setup_clks = s_sec;
    else                setup_clks = (s_pri0 > s_pri1) ? s_pri0 : s_pri1;
  end
endmodule

// File: rtl/pio_phase_seq.sv
module pio_phase_seq
  import pio_timing_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [CNT_W-1:0] setup_clks,
  input  logic [CNT_W-1:0] active_clks,
  input  logic [CNT_W-1:0] recov_clks,
  output logic             rd_stb,
  output logic             wr_stb,
  output logic             busy,
  output logic             done
);
  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] act_q, act_d;
  logic [CNT_W-1:0] rec_q, rec_d;
  logic             wr_q, wr_d;
  logic             last;

  assign last = (cnt_q == CNT_W'(1));

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    act_d = act_q;
    rec_d = rec_q;
    wr_d  = wr_q;
    case (ph_q)
      PH_IDLE: if (req_valid) begin
        ph_d  = PH_SETUP;
        cnt_d = setup_clks;
        act_d = active_clks;
        rec_d = recov_clks;
        wr_d  = req_write;
      end
      PH_SETUP: begin
        if (last) begin ph_d = PH_ACT; cnt_d = act_q; end
        else      cnt_d = cnt_q - CNT_W'(1);
      end
      PH_ACT: begin
        if (last) begin ph_d = PH_REC; cnt_d = rec_q; end
        else      cnt_d = cnt_q - CNT_W'(1);
      end
      default: begin
        if (last) ph_d = PH_IDLE;
        else      cnt_d = cnt_q - CNT_W'(1);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      act_q <= '0;
      rec_q <= '0;
      wr_q  <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      act_q <= act_d;
      rec_q <= rec_d;
      wr_q  <= wr_d;
    end
  end

  assign busy   = (ph_q != PH_IDLE);
  assign rd_stb = (ph_q == PH_ACT) && !wr_q;
  assign wr_stb = (ph_q == PH_ACT) &&  wr_q;
  assign done   = (ph_q == PH_REC) && last;
endmodule

// File: rtl/pio_strobe_gen.sv
module pio_strobe_gen
  import pio_timing_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  input  logic       req_valid,
  input  logic       req_write,
  input  logic [1:0] req_drive,
  output logic       rd_stb,
  output logic       wr_stb,
  output logic       busy,
  output logic       done
);
  logic [CNT_W-1:0] setup_clks, active_clks, recov_clks;

  pio_timing_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .we          (reg_we),
    .addr        (reg_addr),
    .wdata       (reg_wdata),
    .drive       (req_drive),
    .setup_clks  (setup_clks),
    .active_clks (active_clks),
    .recov_clks  (recov_clks)
  );

  pio_phase_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .setup_clks  (setup_clks),
    .active_clks (active_clks),
    .recov_clks  (recov_clks),
    .rd_stb      (rd_stb),
    .wr_stb      (wr_stb),
    .busy        (busy),
    .done        (done)
  );
endmodule

// File: rtl/pio_strobe_chk.sv
module pio_strobe_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic rd_stb,
  input logic wr_stb,
  input logic busy,
  input logic done
);
  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && wr_stb));

  p_strobe_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb || wr_stb) |-> busy);

  p_done_in_rec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy && !rd_stb && !wr_stb));

  p_done_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  p_busy_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  p_idle_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid) |=> busy);

  p_setup_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> (!rd_stb && !wr_stb));

  p_rec_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_stb) || $fell(wr_stb)) |-> !done);

  p_kind_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> !wr_stb);
endmodule

bind pio_strobe_gen pio_strobe_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .rd_stb    (rd_stb),
  .wr_stb    (wr_stb),
  .busy      (busy),
  .done      (done)
);

// File: tb/tb_pio_strobe_gen.sv
`timescale 1ns/1ps
module tb_pio_strobe_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_we;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata;
  logic       req_valid;
  logic       req_write;
  logic [1:0] req_drive;
  logic       rd_stb, wr_stb, busy, done;

  int nchk = 0;
  int nfail = 0;
  logic [7:0] m_data [4];
  logic [7:0] m_set  [3];

  always #4 clk = ~clk;

  pio_strobe_gen dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .req_valid(req_valid), .req_write(req_write),
    .req_drive(req_drive), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .busy(busy), .done(done)
  );

  function automatic int f_act(input logic [7:0] b);
    int v = int'(b[7:4]);
    return (v == 0) ? 16 : v;
  endfunction

  function automatic int f_rec(input logic [7:0] b);
    int v = int'(b[3:0]);
    return (v == 0) ? 16 : v + 1;
  endfunction

  function automatic int f_scode(input logic [7:0] b);
    case (b[7:6])
      2'b00: return 4;
      2'b01: return 2;
      2'b10: return 3;
      default: return 5;
    endcase
  endfunction

  function automatic int f_setup(input int drv);
    int a, b;
    if (drv >= 2) return f_scode(m_set[2]);
    a = f_scode(m_set[0]);
    b = f_scode(m_set[1]);
    return (a > b) ? a : b;
  endfunction

  task automatic check(input bit ok, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic model_write(input logic [2:0] a, input logic [7:0] d);
    if (a < 3'd4)       m_data[a[1:0]] = d;
    else if (a < 3'd7)  m_set[a - 3'd4] = d;
  endtask

  task automatic do_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    model_write(a, d);
  endtask

  task automatic run_op(input int drv, input bit wr, input string tag,
                        input bit mid_wr, input logic [2:0] mid_a, input logic [7:0] mid_d,
                        input bit inject);
    int es, ea, er, ns, na, nr, phase, wrong, ndone, done_at, n;
    es = f_setup(drv); ea = f_act(m_data[drv]); er = f_rec(m_data[drv]);
    ns = 0; na = 0; nr = 0; phase = 0; wrong = 0; ndone = 0; done_at = -1; n = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_drive = 2'(drv);
    @(negedge clk);
    req_valid = 1'b0;
    while (busy && n < 100) begin
      if ((wr ? rd_stb : wr_stb)) wrong++;
      if (done) begin ndone++; done_at = n; end
      if ((wr ? wr_stb : rd_stb)) begin
        if (phase == 2) wrong++;
        phase = 1; na++;
      end else if (phase == 0) ns++;
      else begin phase = 2; nr++; end
      if (mid_wr && n == 0) begin reg_we = 1'b1; reg_addr = mid_a; reg_wdata = mid_d; end
      if (mid_wr && n == 1) begin reg_we = 1'b0; model_write(mid_a, mid_d); end
      if (inject && n == es + 1) begin
        req_valid = 1'b1; req_write = ~wr; req_drive = 2'(drv ^ 1);
      end
      if (inject && n == es + 2) req_valid = 1'b0;
      @(negedge clk);
      n++;
    end
    check(ns == es, {tag, " R2 setup length"}, ns, es);
    check(na == ea, {tag, " R3 active length"}, na, ea);
    check(nr == er, {tag, " R4 recovery length"}, nr, er);
    check(wrong == 0, {tag, " R2 strobe kind/order"}, wrong, 0);
    check(ndone == 1 && done_at == n - 1, {tag, " R2 done on last clock"}, done_at, n - 1);
    if (inject) begin
      repeat (3) @(negedge clk);
      check(!busy, {tag, " R8 request while busy dropped"}, int'(busy), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    req_valid = 1'b0; req_write = 1'b0; req_drive = '0;
    for (int i = 0; i < 4; i++) m_data[i] = 8'h00;
    for (int i = 0; i < 3; i++) m_set[i] = 8'hC0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !rd_stb && !wr_stb, "R1 idle outputs after reset",
          int'({busy, done, rd_stb, wr_stb}), 0);

    run_op(0, 1'b0, "R1 reset drive0 read", 1'b0, 3'd0, 8'h00, 1'b0);
    run_op(3, 1'b1, "R1 reset drive3 write", 1'b0, 3'd0, 8'h00, 1'b0);

    do_write(3'd1, 8'h1F);
    run_op(1, 1'b0, "R3 R4 nibble 1/F", 1'b0, 3'd0, 8'h00, 1'b0);
    do_write(3'd2, 8'hF1);
    run_op(2, 1'b1, "R3 R4 nibble F/1", 1'b0, 3'd0, 8'h00, 1'b0);
    do_write(3'd3, 8'h2E);
    run_op(3, 1'b0, "R3 R4 nibble 2/E", 1'b0, 3'd0, 8'h00, 1'b0);

    do_write(3'd4, 8'h40);
    do_write(3'd5, 8'h7F);
    run_op(0, 1'b0, "R5 code01 low bits ignored", 1'b0, 3'd0, 8'h00, 1'b0);
    do_write(3'd5, 8'h80);
    run_op(0, 1'b1, "R6 slower other drive", 1'b0, 3'd0, 8'h00, 1'b0);
    do_write(3'd4, 8'h00);
    run_op(1, 1'b0, "R6 slower own channel", 1'b0, 3'd0, 8'h00, 1'b0);

    do_write(3'd6, 8'h3F);
    run_op(2, 1'b0, "R7 shared code00", 1'b0, 3'd0, 8'h00, 1'b0);
    do_write(3'd4, 8'hC0);
    run_op(3, 1'b1, "R7 ignores primary setup", 1'b0, 3'd0, 8'h00, 1'b0);

    do_write(3'd7, 8'h00);
    run_op(3, 1'b0, "R10 address 7 no effect", 1'b0, 3'd0, 8'h00, 1'b0);

    run_op(1, 1'b0, "R9 write during cycle", 1'b1, 3'd1, 8'h33, 1'b0);
    run_op(1, 1'b1, "R9 write applies next", 1'b0, 3'd0, 8'h00, 1'b0);
    run_op(0, 1'b0, "R9 setup write during cycle", 1'b1, 3'd5, 8'h40, 1'b0);

    run_op(2, 1'b1, "R8 request while busy", 1'b0, 3'd0, 8'h00, 1'b1);

    for (int it = 0; it < 60; it++) begin
      int nw = int'($urandom_range(0, 3));
      for (int k = 0; k < nw; k++)
        do_write(3'($urandom_range(0, 7)), 8'($urandom));
      run_op(int'($urandom_range(0, 3)), 1'($urandom), "R2 random",
             1'b0, 3'd0, 8'h00, (it % 10) == 5);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule